// File: doc/BRIEF.md
# DDR3 Write Latency Scheduler

This block sits on the controller side of a DDR3 command path. It watches every mode register set command and picks out the ones that target mode register 2. It checks the captured value and keeps the last legal one as the active write-timing setting. The settings it holds are the CAS write latency code, the dynamic on-die-termination strength, the auto self refresh enable and the extended temperature self refresh select. The termination and self refresh settings are exported in decoded form for the surrounding controller logic.

For every WRITE command the block adds the active CAS write latency to an additive latency supplied by the first-mode-register logic, saturating at 31 cycles. It raises a one-cycle launch strobe that many cycles after the command. It then marks a burst of consecutive data slots with a beat index. Pending writes travel as tokens in a shift register, so writes spaced at least one burst apart each produce their own launch in order. A new legal setting that arrives while writes are still in flight is parked and applied once the pipeline has drained.

Top module: `ddr3_wl_sched`

## Requirements
- R1: After reset the active setting is CAS write latency code 000 (5 cycles), termination code 00, auto self refresh off and normal temperature range; `wr_launch`, `beat_valid` and `mr2_err` are low.
- R2: Only a mode register set command (`cmd_code` = 2'b01) whose `cmd_bank` equals 3'b010 updates the setting; the same command with any other bank value leaves every output unchanged.
- R3: The latency code in `cmd_addr[5:3]` maps codes 0 to 5 to 5 to 10 cycles, shown on `cwl_cyc`; `wl_cyc` equals `cwl_cyc` plus `add_lat`, saturated at 31.
- R4: A WRITE (`cmd_code` = 2'b10) presented in cycle t makes `wr_launch` high in cycle t+WL only, where WL is `wl_cyc` when the WRITE is taken; `beat_valid` is high in cycles t+WL to t+WL+3 with `beat_idx` 0, 1, 2, 3.
- R5: If any of `cmd_addr` bits 13, 12, 11, 8, 2, 1 or 0 is set in a command that targets the register, `mr2_err` is high for exactly the next cycle and the setting is left unchanged.
- R6: Latency codes 3'b110 and 3'b111, and termination code 2'b11, are illegal: `mr2_err` pulses for one cycle and the setting is left unchanged.
- R7: `cmd_addr[10:9]` is shown on `odt_mode` (00 off, 01 RZQ/4, 10 RZQ/2), `cmd_addr[6]` on `asr_en`, and `cmd_addr[7]` on `srt_ext` (1 = extended range). A legal command taken while idle is visible in the next cycle.
- R8: `bin_mismatch` is high exactly when the active latency code differs from `speed_bin`, which names the code required by the clock period band.
- R9: WRITEs spaced at least 4 cycles apart under an unchanged setting each produce their own launch and 4-beat burst, in issue order.
- R10: A legal command taken while a write token or burst is pending does not change the outputs until the pipeline has drained. It is then applied, and the latest such command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 2 | Command: 00 none, 01 mode register set, 10 WRITE, 11 other |
| cmd_bank | input | 3 | Bank address; 3'b010 selects the write-timing register |
| cmd_addr | input | 14 | Address bus carrying the register value |
| add_lat | input | 5 | Additive latency in cycles |
| speed_bin | input | 3 | Latency code required by the clock period band |
| wr_launch | output | 1 | One-cycle strobe for the first data beat |
| beat_valid | output | 1 | High on each data slot of a burst |
| beat_idx | output | 2 | Index of the current beat |
| cwl_cyc | output | 4 | Active CAS write latency in cycles |
| wl_cyc | output | 5 | Total write latency in cycles |
| odt_mode | output | 2 | Dynamic termination setting |
| asr_en | output | 1 | Auto self refresh enable |
| srt_ext | output | 1 | Extended temperature self refresh select |
| mr2_err | output | 1 | One-cycle pulse on a rejected register value |
| bin_mismatch | output | 1 | Active latency code differs from the speed bin |

## Verification
Register results and `mr2_err` are due one cycle after the command. `cwl_cyc`, `wl_cyc` and `bin_mismatch` follow the active setting and the current inputs in that same cycle. The launch strobe is due exactly WL cycles after the WRITE, and the beats follow in the next three cycles. A held setting appears in the second cycle after the last beat. The bench counts cycles at every rising edge, drives and samples at falling edges, and records each expected launch and beat in a ring indexed by the cycle in which it is due. A monitor then compares every cycle against that ring, so an early, late, missing or extra strobe is reported.

// File: rtl/ddr3_wl_pkg.sv
package ddr3_wl_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_MRS   = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_OTHER = 2'b11
    } cmd_e;

    typedef struct packed {
        logic [2:0] cwl_code;
        logic [1:0] odt;
        logic       asr;
        logic       srt;
    } mr2_cfg_t;

    localparam int          ADDR_W       = 14;
    localparam int          BANK_W       = 3;
    localparam logic [2:0]  MR2_SEL      = 3'b010;
    localparam logic [13:0] MR2_RSV_MASK = 14'b11100100000111;
    localparam logic [2:0]  CWL_MAX_CODE = 3'd5;
    localparam logic [1:0]  ODT_BAD_CODE = 2'b11;
    localparam int          CWL_BASE     = 5;

    localparam mr2_cfg_t MR2_RESET = '{cwl_code: 3'd0, odt: 2'd0, asr: 1'b0, srt: 1'b0};

    function automatic logic [3:0] cwl_cycles(input logic [2:0] code);
        return 4'(CWL_BASE) + {1'b0, code};
    endfunction

endpackage

// File: rtl/mr2_check.sv
module mr2_check
    import ddr3_wl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output mr2_cfg_t          cfg,
    output logic              rsv_bad,
    output logic              code_bad
);

    always_comb begin
        cfg.cwl_code = addr[5:3];
        cfg.odt      = addr[10:9];
        cfg.asr      = addr[6];
        cfg.srt      = addr[7];
        rsv_bad      = |(addr & MR2_RSV_MASK);
        code_bad     = (addr[5:3] > CWL_MAX_CODE) || (addr[10:9] == ODT_BAD_CODE);
    end

endmodule

// File: rtl/wr_delay_line.sv
module wr_delay_line #(
    parameter int MAX_WL = 31,
    localparam int WL_W  = $clog2(MAX_WL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_in,
    input  logic [WL_W-1:0] wl,
    output logic            tap,
    output logic            busy
);

    typedef struct packed {
        logic [MAX_WL-1:0] sr;
    } dl_state_t;

    dl_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sr = st_q.sr >> 1;
        for (int i = 0; i < MAX_WL; i++) begin
            if (wr_in && (wl == WL_W'(i + 1))) begin
                st_d.sr[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap  = st_q.sr[0];
    assign busy = |st_q.sr;

    // R4: an accepted write always leaves a pending token behind
    a_r4_token_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_in && wl != '0) |=> busy);

    // R9: tokens only move toward the tap, never appear from nowhere
    a_r9_no_spurious_tap: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_in) |=> !tap);

endmodule

// File: rtl/burst_beats.sv
module burst_beats #(
    parameter int BEATS = 4,
    localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic             active
);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
    } bb_state_t;

    bb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = IDX_W'(BEATS - 1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid  = start || (st_q.cnt != '0);
    assign idx    = start ? '0 : IDX_W'(BEATS - int'(st_q.cnt));
    assign active = (st_q.cnt != '0);

    // R4: the beat after a launch carries index 1
    generate
        if (BEATS > 1) begin : g_multi
            a_r4_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> (valid && idx == IDX_W'(1)));
        end
    endgenerate

    // R4: a beat index never reaches the burst length
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(idx) < BEATS));

endmodule

// File: rtl/ddr3_wl_sched.sv
module ddr3_wl_sched
    import ddr3_wl_pkg::*;
#(
    parameter int MAX_WL = 31,
    parameter int BEATS  = 4,
    localparam int WL_W  = $clog2(MAX_WL + 1),
    localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_code,
    input  logic [2:0]       cmd_bank,
    input  logic [13:0]      cmd_addr,
    input  logic [WL_W-1:0]  add_lat,
    input  logic [2:0]       speed_bin,
    output logic             wr_launch,
    output logic             beat_valid,
    output logic [IDX_W-1:0] beat_idx,
    output logic [3:0]       cwl_cyc,
    output logic [WL_W-1:0]  wl_cyc,
    output logic [1:0]       odt_mode,
    output logic             asr_en,
    output logic             srt_ext,
    output logic             mr2_err,
    output logic             bin_mismatch
);

    typedef struct packed {
        mr2_cfg_t cfg;
        mr2_cfg_t held;
        logic     held_v;
        logic     err;
    } top_state_t;

    top_state_t st_d, st_q;

    cmd_e            cmd;
    mr2_cfg_t        new_cfg;
    logic            rsv_bad, code_bad;
    logic            is_mr2, is_wr, bad, busy;
    logic            line_busy, tap, burst_active;
    logic [WL_W:0]   wl_sum;
    logic [WL_W-1:0] wl_now;

    assign cmd    = cmd_e'(cmd_code);
    assign is_mr2 = (cmd == CMD_MRS) && (cmd_bank == MR2_SEL);
    assign is_wr  = (cmd == CMD_WRITE);
    assign bad    = rsv_bad || code_bad;
    assign busy   = line_busy || burst_active;

    mr2_check u_check (
        .addr     (cmd_addr),
        .cfg      (new_cfg),
        .rsv_bad  (rsv_bad),
        .code_bad (code_bad)
    );

    always_comb begin
        wl_sum = (WL_W + 1)'(cwl_cycles(st_q.cfg.cwl_code)) + (WL_W + 1)'(add_lat);
        if (wl_sum > (WL_W + 1)'(MAX_WL)) begin
            wl_now = WL_W'(MAX_WL);
        end else begin
            wl_now = wl_sum[WL_W-1:0];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = is_mr2 && bad;
        if (is_mr2 && !bad) begin
            if (!busy) begin
                st_d.cfg    = new_cfg;
                st_d.held_v = 1'b0;
            end else begin
                st_d.held   = new_cfg;
                st_d.held_v = 1'b1;
            end
        end else if (st_q.held_v && !busy && !is_wr) begin
            st_d.cfg    = st_q.held;
            st_d.held_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg    <= MR2_RESET;
            st_q.held   <= MR2_RESET;
            st_q.held_v <= 1'b0;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    wr_delay_line #(.MAX_WL(MAX_WL)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_in (is_wr),
        .wl    (wl_now),
        .tap   (tap),
        .busy  (line_busy)
    );

    burst_beats #(.BEATS(BEATS)) u_beats (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tap),
        .valid  (beat_valid),
        .idx    (beat_idx),
        .active (burst_active)
    );

    assign wr_launch    = tap;
    assign cwl_cyc      = cwl_cycles(st_q.cfg.cwl_code);
    assign wl_cyc       = wl_now;
    assign odt_mode     = st_q.cfg.odt;
    assign asr_en       = st_q.cfg.asr;
    assign srt_ext      = st_q.cfg.srt;
    assign mr2_err      = st_q.err;
    assign bin_mismatch = (st_q.cfg.cwl_code != speed_bin);

    // R5 / R6: a rejected value raises the error and leaves the setting alone
    a_r5_bad_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mr2 && bad) |=> (mr2_err && $stable(st_q.cfg)));

    // R2: commands to other registers never disturb the setting while idle
    a_r2_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_MRS) && !is_mr2 && !st_q.held_v) |=> $stable(st_q.cfg));

    // R10: nothing is applied while a write is in flight
    a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.cfg));

    // R6: the active latency code is always a legal one
    a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.cwl_code <= CWL_MAX_CODE) && (st_q.cfg.odt != ODT_BAD_CODE));

    // R3: total latency is never below the CAS write latency
    a_r3_wl_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_cyc >= WL_W'(cwl_cyc)));

endmodule

// File: tb/tb_ddr3_wl_sched.sv
`timescale 1ns/1ps
module tb_ddr3_wl_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_code = 2'b00;
    logic [2:0]  cmd_bank = 3'b000;
    logic [13:0] cmd_addr = '0;
    logic [4:0]  add_lat = '0;
    logic [2:0]  speed_bin = '0;
    logic        wr_launch, beat_valid, asr_en, srt_ext, mr2_err, bin_mismatch;
    logic [1:0]  beat_idx, odt_mode;
    logic [3:0]  cwl_cyc;
    logic [4:0]  wl_cyc;

    ddr3_wl_sched dut (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .add_lat(add_lat), .speed_bin(speed_bin),
        .wr_launch(wr_launch), .beat_valid(beat_valid), .beat_idx(beat_idx),
        .cwl_cyc(cwl_cyc), .wl_cyc(wl_cyc), .odt_mode(odt_mode), .asr_en(asr_en),
        .srt_ext(srt_ext), .mr2_err(mr2_err), .bin_mismatch(bin_mismatch)
    );

    always #2.5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit mon_en = 0;
    string mon_tag = "R4";
    logic [3:0] exp_ring [64];

    // bench model of the active setting
    int m_code = 0, m_odt = 0, m_asr = 0, m_srt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int f_cwl(input int code);
        return 5 + code;
    endfunction

    function automatic int f_wl(input int code, input int al);
        int s;
        s = f_cwl(code) + al;
        return (s > 31) ? 31 : s;
    endfunction

    function automatic logic [13:0] f_addr(input int code, input int odt, input int asr, input int srt);
        return 14'((odt << 9) | (srt << 7) | (asr << 6) | (code << 3));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic chk_cfg(input string req);
        chk(req, int'(cwl_cyc), f_cwl(m_code));
        chk(req, int'(odt_mode), m_odt);
        chk(req, int'(asr_en), m_asr);
        chk(req, int'(srt_ext), m_srt);
    endtask

    // monitor: {launch, valid, idx} against the expected ring
    always @(negedge clk) begin
        if (mon_en) begin
            logic [3:0] e, a;
            e = exp_ring[cyc % 64];
            a = {wr_launch, beat_valid, beat_valid ? beat_idx : 2'b00};
            chk(mon_tag, int'(a), int'(e));
            exp_ring[cyc % 64] = 4'b0;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic mrs(input logic [2:0] bank, input logic [13:0] addr);
        cmd_code = 2'b01;
        cmd_bank = bank;
        cmd_addr = addr;
        @(negedge clk);
        cmd_code = 2'b00;
        cmd_bank = 3'b000;
        cmd_addr = '0;
    endtask

    task automatic wr(input int wl);
        for (int k = 0; k < 4; k++) begin
            exp_ring[(cyc + wl + k) % 64] = {(k == 0) ? 1'b1 : 1'b0, 1'b1, 2'(k)};
        end
        cmd_code = 2'b10;
        @(negedge clk);
        cmd_code = 2'b00;
    endtask

    task automatic set_cfg(input int code, input int odt, input int asr, input int srt);
        mrs(3'b010, f_addr(code, odt, asr, srt));
        m_code = code; m_odt = odt; m_asr = asr; m_srt = srt;
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int rsv_bits [7] = '{13, 12, 11, 8, 2, 1, 0};
        for (int i = 0; i < 64; i++) exp_ring[i] = 4'b0;
        void'($urandom(32'd2024));
        step(3);
        rst_n = 1'b1;
        step(1);
        mon_en = 1;

        // R1: reset state
        chk_cfg("R1");
        chk("R1", int'(wr_launch), 0);
        chk("R1", int'(beat_valid), 0);
        chk("R1", int'(mr2_err), 0);

        // R3 / R4: AL=5, CWL=6 gives WL=11
        add_lat = 5'd5;
        set_cfg(1, 0, 0, 0);
        chk_cfg("R3");
        chk("R3", int'(wl_cyc), 11);
        chk("R3", int'(mr2_err), 0);
        wr(11);
        step(20);

        // R2: other banks ignored
        mrs(3'b000, f_addr(3, 1, 1, 1));
        chk_cfg("R2");
        mrs(3'b110, f_addr(4, 2, 0, 1));
        chk_cfg("R2");
        mrs(3'b011, f_addr(2, 0, 1, 0));
        chk_cfg("R2");

        // R7: field decode
        set_cfg(2, 1, 1, 1);
        chk_cfg("R7");
        set_cfg(2, 2, 0, 1);
        chk_cfg("R7");

        // R5: each reserved bit rejects the value
        foreach (rsv_bits[j]) begin
            mrs(3'b010, f_addr(4, 0, 1, 0) | (14'd1 << rsv_bits[j]));
            chk("R5", int'(mr2_err), 1);
            chk_cfg("R5");
            step(1);
            chk("R5", int'(mr2_err), 0);
        end

        // R6: illegal latency and termination codes
        mrs(3'b010, f_addr(6, 0, 0, 0));
        chk("R6", int'(mr2_err), 1);
        chk_cfg("R6");
        mrs(3'b010, f_addr(7, 1, 0, 0));
        chk("R6", int'(mr2_err), 1);
        chk_cfg("R6");
        mrs(3'b010, f_addr(3, 3, 1, 1));
        chk("R6", int'(mr2_err), 1);
        chk_cfg("R6");

        // R8: speed bin comparison
        speed_bin = 3'd2;
        step(1);
        chk("R8", int'(bin_mismatch), 0);
        speed_bin = 3'd5;
        step(1);
        chk("R8", int'(bin_mismatch), 1);
        speed_bin = 3'd7;
        step(1);
        chk("R8", int'(bin_mismatch), 1);

        // R3: saturation at 31, and the minimum of 5
        set_cfg(5, 0, 0, 0);
        add_lat = 5'd31;
        step(1);
        chk("R3", int'(wl_cyc), 31);
        wr(31);
        step(40);
        set_cfg(0, 0, 0, 0);
        add_lat = 5'd0;
        step(1);
        chk("R3", int'(wl_cyc), 5);
        wr(5);
        step(12);

        // R10: settings held while a write is in flight; latest wins
        add_lat = 5'd2;
        step(1);
        wr(7);
        mrs(3'b010, f_addr(4, 2, 1, 0));
        mrs(3'b010, f_addr(3, 1, 0, 1));
        chk_cfg("R10");
        step(3);
        chk_cfg("R10");
        chk("R10", int'(wl_cyc), 7);
        step(12);
        m_code = 3; m_odt = 1; m_asr = 0; m_srt = 1;
        chk_cfg("R10");

        // R9: random phases with back-to-back writes
        mon_tag = "R9";
        for (int ph = 0; ph < 6; ph++) begin
            int code, al, wl;
            code = int'($urandom % 6);
            al = int'($urandom % f_cwl(code));
            add_lat = 5'(al);
            set_cfg(code, int'($urandom % 3), int'($urandom % 2), int'($urandom % 2));
            chk_cfg("R7");
            wl = f_wl(code, al);
            chk("R3", int'(wl_cyc), wl);
            for (int w = 0; w < 8; w++) begin
                wr(wl);
                step(3 + int'($urandom % 4));
            end
            step(wl + 6);
            mrs(3'b010, f_addr(code, 0, 0, 0) | 14'(1 << (($urandom % 2) * 11)) | 14'd4);
            chk("R5", int'(mr2_err), 1);
            chk_cfg("R5");
            step(2);
        end

        mon_en = 0;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule